// File: doc/BRIEF.md
# DRAM DLL Relock Command Guard

This block sits on the command path between a memory controller's command generator and a double-data-rate SDRAM. It follows every command the controller issues and keeps a shadow copy of the device's extended mode register. From that copy and from self-refresh entry and exit it knows whether the device's delay-locked loop is running and how long ago it last started. It also tracks whether a register load is still settling.

From this state the block produces two qualifiers, `rd_ready` and `wr_ready`. The controller holds a Read or Write while its qualifier is low. A mode-register load starts a short settle window, and `mrs_busy` is high for that window. The block never drops a command. If a command is issued against the rules anyway, a violation flag is raised and stays raised until reset. Reset clears the shadow register to all zeros, so the DLL counts as enabled and drive strength as normal, and it starts a fresh relock window. The weak-drive and output-isolation-enable bits are stored only and have no effect on readiness.

Command codes on `cmd`: 0 no-op, 1 Read, 2 Write, 3 mode-register set, 4 self-refresh entry, 5 self-refresh exit, 6 activate, 7 precharge. Shadow register fields: bit 0 is DLL disable (1 = disabled), bit 1 is weak drive, bit 2 is output-isolation enable.

Top module: `dll_cmd_guard`

## Requirements
- R1: A mode-register set with `ba` = 2'b01 (bit 0 set, bit 1 clear) copies `mr_data` into the shadow register, which is visible on `emr_value` from the next cycle. A mode-register set with any other `ba` value leaves `emr_value` unchanged.
- R2: Reset sets `emr_value` to zero. The value is then kept through every other command until the next R1 load.
- R3: A load of the extended register (`ba` = 2'b01) while `banks_idle` is low sets `violation`. A base-register load (`ba` = 2'b00) is not checked against `banks_idle`.
- R4: After any mode-register set, `mrs_busy` is high for LOAD_WAIT cycles and both qualifiers are low during that time. Any command other than no-op issued during that time sets `violation`. A command issued once `mrs_busy` has fallen does not.
- R5: After reset is released, `rd_ready` stays low for exactly RELOCK clock edges and then rises.
- R6: Writing bit 0 = 1 turns `dll_on` and `rd_ready` low. A later load with bit 0 = 0 restarts a RELOCK-edge wait before `rd_ready` rises. Writes stay allowed in both cases.
- R7: Self-refresh entry turns `dll_on`, `rd_ready` and `wr_ready` low. Self-refresh exit turns `dll_on` high, and both qualifiers stay low for RELOCK edges after the exit.
- R8: A Read issued while `rd_ready` is low, or a Write issued while `wr_ready` is low, sets `violation`. A Read or Write issued while its qualifier is high does not.
- R9: `violation` stays high once set, whatever commands follow, and only reset clears it.
- R10: Bits 1 and 2 of the shadow register are stored, but changing them while the DLL stays enabled neither blocks reads nor restarts the relock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command code issued this cycle |
| ba | input | 2 | Bank-address bits that come with the command |
| mr_data | input | EMR_W | Register value carried by a mode-register set |
| banks_idle | input | 1 | High when every bank is precharged |
| rd_ready | output | 1 | A Read may be issued this cycle |
| wr_ready | output | 1 | A Write may be issued this cycle |
| mrs_busy | output | 1 | A register load is still settling |
| violation | output | 1 | Sticky flag for a rule broken by the controller |
| dll_on | output | 1 | The DLL is currently considered enabled |
| emr_value | output | EMR_W | Shadow copy of the extended mode register |

## Verification
The relock window is checked edge by edge in three situations, each with a different expected result for writes. After reset only reads wait. After DLL re-enable only reads wait, and writes must stay ready the whole time. After self-refresh exit both reads and writes wait. A sweep of every `ba` code against every register value tells the extended-register target apart from the base register. It also shows that the drive and isolation bits never gate reads, and that turning the DLL back on gates reads only until relock completes. Each violation cause is applied on its own after a fresh reset: a load while banks are not idle, an early Read, a Write during self-refresh, and a command one cycle before and exactly at the end of the load wait. A run of legal traffic afterwards shows that the flag does not clear.

// File: rtl/dllg_pkg.sv
package dllg_pkg;
    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_READ     = 3'd1,
        CMD_WRITE    = 3'd2,
        CMD_MRS      = 3'd3,
        CMD_SR_ENTER = 3'd4,
        CMD_SR_EXIT  = 3'd5,
        CMD_ACT      = 3'd6,
        CMD_PRE      = 3'd7
    } cmd_e;

    localparam logic [1:0] BA_EXT_REG  = 2'b01;
    localparam int         DLL_OFF_BIT = 0;
    localparam int         WEAK_BIT    = 1;
    localparam int         ISO_BIT     = 2;
    localparam int         MIN_EMR_W   = 3;
endpackage

// File: rtl/dllg_mode_state.sv
module dllg_mode_state #(
    parameter int EMR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emr_load_i,
    input  logic [EMR_W-1:0] emr_data_i,
    input  logic             sr_enter_i,
    input  logic             sr_exit_i,
    output logic [EMR_W-1:0] emr_o,
    output logic             in_sr_o,
    output logic             dll_on_o,
    output logic             sr_exit_ok_o
);
    typedef struct packed {
        logic [EMR_W-1:0] emr;
        logic             in_sr;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (emr_load_i) begin
            st_d.emr = emr_data_i;
        end
        if (sr_enter_i) begin
            st_d.in_sr = 1'b1;
        end else if (sr_exit_i) begin
            st_d.in_sr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign emr_o        = st_q.emr;
    assign in_sr_o      = st_q.in_sr;
    assign dll_on_o     = !st_q.emr[dllg_pkg::DLL_OFF_BIT] && !st_q.in_sr;
    assign sr_exit_ok_o = sr_exit_i && st_q.in_sr;

    assert_emr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !emr_load_i |=> $stable(emr_o));
    assert_sr_dll_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter_i |=> !dll_on_o);
endmodule

// File: rtl/dllg_relock.sv
module dllg_relock #(
    parameter int RELOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_on_i,
    input  logic sr_exit_i,
    output logic relock_done_o,
    output logic wr_hold_o
);
    localparam int CW = $clog2(RELOCK + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wr_gate;
    } relock_st_t;

    relock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!dll_on_i) begin
            st_d.cnt = CW'(RELOCK);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (sr_exit_i) begin
            st_d.wr_gate = 1'b1;
        end else if (st_q.cnt == '0) begin
            st_d.wr_gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= CW'(RELOCK);
            st_q.wr_gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign relock_done_o = (st_q.cnt == '0);
    assign wr_hold_o     = st_q.wr_gate && (st_q.cnt != '0);

    assert_no_lock_while_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dll_on_i |=> !relock_done_o);
    assert_exit_holds_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit_i |=> wr_hold_o);
endmodule

// File: rtl/dllg_load_wait.sv
module dllg_load_wait #(
    parameter int LOAD_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int WW = $clog2(LOAD_WAIT + 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } wait_st_t;

    wait_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = WW'(LOAD_WAIT);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != '0);

    assert_busy_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
endmodule

// File: rtl/dll_cmd_guard.sv
module dll_cmd_guard #(
    parameter int EMR_W     = 3,
    parameter int RELOCK    = 200,
    parameter int LOAD_WAIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [1:0]       ba,
    input  logic [EMR_W-1:0] mr_data,
    input  logic             banks_idle,
    output logic             rd_ready,
    output logic             wr_ready,
    output logic             mrs_busy,
    output logic             violation,
    output logic             dll_on,
    output logic [EMR_W-1:0] emr_value
);
    import dllg_pkg::*;

    typedef struct packed {
        logic viol;
    } top_st_t;

    cmd_e    cmd_c;
    logic    is_read, is_write, is_mrs, is_nop;
    logic    emr_load, sr_enter, sr_exit, sr_exit_ok;
    logic    in_sr, relock_done, wr_hold;
    top_st_t st_d, st_q;

    assign cmd_c    = cmd_e'(cmd);
    assign is_nop   = (cmd_c == CMD_NOP);
    assign is_read  = (cmd_c == CMD_READ);
    assign is_write = (cmd_c == CMD_WRITE);
    assign is_mrs   = (cmd_c == CMD_MRS);
    assign sr_enter = (cmd_c == CMD_SR_ENTER);
    assign sr_exit  = (cmd_c == CMD_SR_EXIT);
    assign emr_load = is_mrs && (ba == BA_EXT_REG);

    dllg_mode_state #(.EMR_W(EMR_W)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .emr_load_i   (emr_load),
        .emr_data_i   (mr_data),
        .sr_enter_i   (sr_enter),
        .sr_exit_i    (sr_exit),
        .emr_o        (emr_value),
        .in_sr_o      (in_sr),
        .dll_on_o     (dll_on),
        .sr_exit_ok_o (sr_exit_ok)
    );

    dllg_relock #(.RELOCK(RELOCK)) u_relock (
        .clk           (clk),
        .rst_n         (rst_n),
        .dll_on_i      (dll_on),
        .sr_exit_i     (sr_exit_ok),
        .relock_done_o (relock_done),
        .wr_hold_o     (wr_hold)
    );

    dllg_load_wait #(.LOAD_WAIT(LOAD_WAIT)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (is_mrs),
        .busy_o (mrs_busy)
    );

    assign rd_ready = dll_on && relock_done && !mrs_busy;
    assign wr_ready = !in_sr && !wr_hold && !mrs_busy;

    always_comb begin
        st_d = st_q;
        if ((emr_load && !banks_idle) ||
            (is_read && !rd_ready) ||
            (is_write && !wr_ready) ||
            (mrs_busy && !is_nop)) begin
            st_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign violation = st_q.viol;

    initial begin
        assert_emr_width_R1: assert (EMR_W >= MIN_EMR_W);
        assert_wait_nonzero_R4: assert (LOAD_WAIT >= 1 && RELOCK >= 1);
    end

    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    assert_busy_load_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (emr_load && !banks_idle) |=> violation);
    assert_early_read_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && !rd_ready) |=> violation);
    assert_read_needs_dll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (dll_on && !in_sr));
endmodule

// File: tb/dll_cmd_guard_tb.sv
module dll_cmd_guard_tb;
    import dllg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int EW         = 3;
    localparam int RELOCK     = 8;
    localparam int LWAIT      = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    cmd;
    logic [1:0]    ba;
    logic [EW-1:0] mr_data;
    logic          banks_idle;
    logic          rd_ready, wr_ready, mrs_busy, violation, dll_on;
    logic [EW-1:0] emr_value;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    dll_cmd_guard #(.EMR_W(EW), .RELOCK(RELOCK), .LOAD_WAIT(LWAIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .mr_data(mr_data),
        .banks_idle(banks_idle), .rd_ready(rd_ready), .wr_ready(wr_ready),
        .mrs_busy(mrs_busy), .violation(violation), .dll_on(dll_on),
        .emr_value(emr_value)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [EW-1:0] d);
        cmd = c; ba = b; mr_data = d;
        @(negedge clk);
        cmd = CMD_NOP;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd = CMD_NOP; banks_idle = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(RELOCK + 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [EW-1:0] emr_exp;
        logic          prev_dis;
        rst_n = 1'b0; cmd = CMD_NOP; ba = 2'b00; mr_data = '0; banks_idle = 1'b1;
        step(2);
        // R2 R5: reset state
        chk("R2 reset emr", emr_value, 0);
        chk("R5 reset rd_ready", rd_ready, 0);
        chk("R5 reset dll_on", dll_on, 1);
        chk("R8 reset wr_ready", wr_ready, 1);
        chk("R4 reset busy", mrs_busy, 0);
        chk("R9 reset violation", violation, 0);
        rst_n = 1'b1;
        for (int n = 0; n <= RELOCK + 2; n++) begin
            chk("R5 relock after reset", rd_ready, (n >= RELOCK) ? 1 : 0);
            step(1);
        end
        issue(CMD_READ, 2'b00, '0);
        issue(CMD_WRITE, 2'b00, '0);
        chk("R8 legal read/write", violation, 0);

        // R1 R6 R10: sweep of bank code against register value
        emr_exp = '0;
        for (int b = 0; b < 4; b++) begin
            for (int d = 0; d < (1 << EW); d++) begin
                prev_dis = emr_exp[0];
                issue(CMD_MRS, 2'(b), EW'(d));
                if (b == 1) emr_exp = EW'(d);
                chk("R1 emr target", emr_value, emr_exp);
                chk("R4 busy after load", mrs_busy, 1);
                chk("R4 read blocked while busy", rd_ready, 0);
                step(LWAIT);
                chk("R4 busy ends", mrs_busy, 0);
                chk("R6 dll_on follows bit0", dll_on, emr_exp[0] ? 0 : 1);
                chk("R10 rd_ready by dll only", rd_ready, (!emr_exp[0] && !prev_dis) ? 1 : 0);
                chk("R6 write allowed", wr_ready, 1);
                if (prev_dis && !emr_exp[0]) step(RELOCK);
            end
        end
        issue(CMD_MRS, 2'b01, '0);
        step(RELOCK);
        chk("R2 emr kept then cleared", emr_value, 0);
        chk("R4 no violation in sweep", violation, 0);

        // R7: self refresh
        issue(CMD_SR_ENTER, 2'b00, '0);
        chk("R7 sr dll off", dll_on, 0);
        chk("R7 sr read blocked", rd_ready, 0);
        chk("R7 sr write blocked", wr_ready, 0);
        step(3);
        chk("R7 sr write still blocked", wr_ready, 0);
        issue(CMD_SR_EXIT, 2'b00, '0);
        for (int k = 0; k <= RELOCK + 1; k++) begin
            chk("R7 dll on after exit", dll_on, 1);
            chk("R7 read wait after exit", rd_ready, (k >= RELOCK) ? 1 : 0);
            chk("R7 write wait after exit", wr_ready, (k >= RELOCK) ? 1 : 0);
            step(1);
        end

        // R6: disable and re-enable through register
        issue(CMD_MRS, 2'b01, 3'b001);
        step(LWAIT);
        issue(CMD_WRITE, 2'b00, '0);
        chk("R6 write with dll off", violation, 0);
        issue(CMD_MRS, 2'b01, 3'b000);
        for (int k = 0; k <= RELOCK + 1; k++) begin
            if (k >= LWAIT) chk("R6 write ready during relock", wr_ready, 1);
            chk("R6 read relock", rd_ready, (k >= RELOCK) ? 1 : 0);
            step(1);
        end
        issue(CMD_MRS, 2'b01, 3'b110);
        step(LWAIT);
        chk("R10 option bits stored", emr_value, 6);
        chk("R10 no relock from option bits", rd_ready, 1);
        issue(CMD_MRS, 2'b01, 3'b000);
        step(LWAIT);
        chk("R8 no violation so far", violation, 0);

        // R3 and R9
        banks_idle = 1'b0;
        issue(CMD_MRS, 2'b00, '0);
        chk("R3 base load unchecked", violation, 0);
        step(LWAIT);
        issue(CMD_MRS, 2'b01, '0);
        chk("R3 ext load banks active", violation, 1);
        banks_idle = 1'b1;
        step(LWAIT);
        for (int i = 0; i < 10; i++) begin
            issue(CMD_WRITE, 2'b00, '0);
            step(1);
        end
        chk("R9 violation sticky", violation, 1);
        do_reset();
        chk("R9 reset clears", violation, 0);

        // R8: early read
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        issue(CMD_READ, 2'b00, '0);
        chk("R8 early read", violation, 1);
        do_reset();

        // R8: write in self refresh
        issue(CMD_SR_ENTER, 2'b00, '0);
        issue(CMD_WRITE, 2'b00, '0);
        chk("R8 write in self refresh", violation, 1);
        issue(CMD_SR_EXIT, 2'b00, '0);
        do_reset();

        // R4: load-wait boundary
        issue(CMD_MRS, 2'b00, '0);
        step(LWAIT);
        issue(CMD_ACT, 2'b00, '0);
        chk("R4 command at wait end", violation, 0);
        step(1);
        issue(CMD_MRS, 2'b00, '0);
        step(LWAIT - 1);
        issue(CMD_ACT, 2'b00, '0);
        chk("R4 command inside wait", violation, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule